// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor that retires one instruction on every rising clock edge. It fetches from an internal instruction store at the program counter and reads two source registers from a 32-entry register file. One datapath pass computes a result, a memory address or a branch decision. The register write and the next program counter are committed at the following edge. The supported operations are word load and store, register add, subtract, AND, OR and signed set-less-than, branch-if-equal and an absolute jump.

Both memories are word arrays inside the block. A preload port writes them while the core is held in reset, so a test harness or a boot path can place code and data before execution starts. Every store is visible at the ports as a one-cycle write strobe with its byte address and data. Register contents can be observed by storing them.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and clears every register. No store strobe appears while reset is asserted.
- R2: Every instruction other than a taken branch or a jump moves the program counter to PC+4. The instruction executed is the instruction-store word at index PC[7:2], so the PC is always word aligned.
- R3: Opcode 0 (bits 31:26) is a register operation. Its fields are rs in bits 25:21, rt in 20:16 and rd in 15:11. The function code in bits 5:0 selects the operation: 32 add, 34 subtract (rs-rt), 36 AND, 37 OR, 42 signed set-less-than (1 or 0). The result is written to rd.
- R4: Opcode 35 loads the data word at byte address rs + sign-extended bits 15:0 into the register named by bits 20:16.
- R5: Opcode 43 raises memWrEn for exactly that cycle. memWrAddr is rs + sign-extended bits 15:0, memWrData is the value of rt, and the word is written to the data store.
- R6: Opcode 4 compares rs with rt. When they are equal the next PC is PC+4 + (sign-extended bits 15:0 shifted left by 2). Otherwise the next PC is PC+4.
- R7: Opcode 2 sets the next PC to {PC+4[31:28], bits 25:0, 2'b00}.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: A register write takes effect at the clock edge that ends its instruction. Operands read in the same cycle see the old value, and the next instruction sees the new one.
- R10: While loadEn is 1, loadData is written at the clock edge to word loadAddr. The data store receives it when loadToData is 1, and the instruction store receives it otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Preload write enable |
| loadToData | input | 1 | Preload target: 1 data store, 0 instruction store |
| loadAddr | input | 6 | Preload word index |
| loadData | input | 32 | Preload word |
| pc | output | 32 | Current program counter |
| memWrEn | output | 1 | Store strobe for the current instruction |
| memWrAddr | output | 32 | Store byte address |
| memWrData | output | 32 | Store data |

## Verification
The register write-back of one instruction and the operand read of the instruction that names the same register share a clock edge. The same holds within one instruction when rd equals rs. A fixed-seed random program chains register operations with freely overlapping source and destination registers. Directed sequences add self-updating operations, writes to register 0 and a load through a base register loaded one cycle earlier. Every store and every PC value is compared against an instruction-level model in the bench, so an operand read that picks up a value too early or too late shows up as a wrong stored word.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [5:0] OP_REG   = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   regDst;    // 1: destination from rd field
    logic   aluSrc;    // 1: second operand is immediate
    logic   memToReg;  // 1: write-back from data store
    logic   regWrite;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluFn_e aluFn;
  } ctrlBus_t;

endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrlBus_t   ctl
);

  aluFn_e regFn;

  // operation select for register-register instructions
  always_comb begin
    unique case (funct)
      FN_SUB:  regFn = ALU_SUB;
      FN_AND:  regFn = ALU_AND;
      FN_OR:   regFn = ALU_OR;
      FN_SLT:  regFn = ALU_SLT;
      default: regFn = ALU_ADD;
    endcase
  end

  // opcode decode
  always_comb begin
    ctl = '{regDst: 1'b0, aluSrc: 1'b0, memToReg: 1'b0, regWrite: 1'b0,
            memWrite: 1'b0, branch: 1'b0, jump: 1'b0, aluFn: ALU_ADD};
    unique case (opcode)
      OP_REG: begin
        ctl.regDst   = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.aluFn    = regFn;
      end
      OP_LOAD: begin
        ctl.aluSrc   = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.regWrite = 1'b1;
      end
      OP_STORE: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.aluFn  = ALU_SUB;
      end
      OP_JUMP: ctl.jump = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  localparam int RA_W     = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] rdAddrA,
  input  logic [RA_W-1:0] rdAddrB,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB,
  input  logic            wrEn,
  input  logic [RA_W-1:0] wrAddr,
  input  logic [XLEN-1:0] wrData
);

  logic [XLEN-1:0] regs [REG_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  aluFn_e          fn,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  always_comb begin
    unique case (fn)
      ALU_AND: y = opA & opB;
      ALU_OR:  y = opA | opB;
      ALU_SUB: y = opA - opB;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: y = opA + opB;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int REG_COUNT  = 32,
  localparam int XLEN      = 32,
  localparam int IA_W      = $clog2(IMEM_WORDS),
  localparam int DA_W      = $clog2(DMEM_WORDS),
  localparam int LOAD_W    = (IA_W > DA_W) ? IA_W : DA_W,
  localparam int RA_W      = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlBus_t          ctl,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [LOAD_W-1:0] loadAddr,
  input  logic [XLEN-1:0]   loadData,
  output logic [XLEN-1:0]   instrWord,
  output logic [XLEN-1:0]   pc,
  output logic              memWrEn,
  output logic [XLEN-1:0]   memWrAddr,
  output logic [XLEN-1:0]   memWrData
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pcPlus4, brTarget, jmpTarget, pcNext;
  logic [XLEN-1:0] rsVal, rtVal, immExt, aluB, aluY, memRd, wbData;
  logic [RA_W-1:0] wbAddr;
  logic            aluZero;

  // fetch
  assign instrWord = imem[pc[IA_W+1:2]];

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr[IA_W-1:0]] <= loadData;
  end

  // next-PC selection
  assign pcPlus4   = pc + 32'd4;
  assign immExt    = {{16{instrWord[15]}}, instrWord[15:0]};
  assign brTarget  = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jmpTarget = {pcPlus4[31:28], instrWord[25:0], 2'b00};

  always_comb begin
    if (ctl.jump)                pcNext = jmpTarget;
    else if (ctl.branch && aluZero) pcNext = brTarget;
    else                         pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  // register file
  assign wbAddr = ctl.regDst ? instrWord[15:11] : instrWord[20:16];
  assign wbData = ctl.memToReg ? memRd : aluY;

  sc_regfile #(.XLEN(XLEN), .REG_COUNT(REG_COUNT)) rf_i (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (instrWord[25:21]),
    .rdAddrB (instrWord[20:16]),
    .rdDataA (rsVal),
    .rdDataB (rtVal),
    .wrEn    (ctl.regWrite && !rst),
    .wrAddr  (wbAddr),
    .wrData  (wbData)
  );

  // execute
  assign aluB = ctl.aluSrc ? immExt : rtVal;

  sc_alu #(.XLEN(XLEN)) alu_i (
    .fn   (ctl.aluFn),
    .opA  (rsVal),
    .opB  (aluB),
    .y    (aluY),
    .zero (aluZero)
  );

  // data store
  assign memRd     = dmem[aluY[DA_W+1:2]];
  assign memWrEn   = ctl.memWrite && !rst;
  assign memWrAddr = aluY;
  assign memWrData = rtVal;

  always_ff @(posedge clk) begin
    if (loadEn && loadToData) dmem[loadAddr[DA_W-1:0]] <= loadData;
    else if (memWrEn)         dmem[aluY[DA_W+1:2]]     <= rtVal;
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int LOAD_W    = ($clog2(IMEM_WORDS) > $clog2(DMEM_WORDS)) ?
                             $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [LOAD_W-1:0] loadAddr,
  input  logic [31:0]       loadData,
  output logic [31:0]       pc,
  output logic              memWrEn,
  output logic [31:0]       memWrAddr,
  output logic [31:0]       memWrData
);

  ctrlBus_t    ctl;
  logic [31:0] instrWord;

  sc_control ctrl_i (
    .opcode (instrWord[31:26]),
    .funct  (instrWord[5:0]),
    .ctl    (ctl)
  );

  sc_datapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .instrWord  (instrWord),
    .pc         (pc),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instrWord,
  input logic        memWrEn
);

  logic [5:0]  op;
  logic [31:0] seqPc, takenPc, jumpPc;
  assign op      = instrWord[31:26];
  assign seqPc   = pc + 32'd4;
  assign takenPc = seqPc + {{14{instrWord[15]}}, instrWord[15:0], 2'b00};
  assign jumpPc  = {seqPc[31:28], instrWord[25:0], 2'b00};

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc == 32'd0));

  p_reset_nostore_r1: assert property (@(posedge clk) rst |-> !memWrEn);

  p_pc_align_r2: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (op != 6'd4 && op != 6'd2) |=> (pc == $past(seqPc)));

  p_branch_dest_r6: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4) |=> (pc == $past(seqPc) || pc == $past(takenPc)));

  p_jump_dest_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> (pc == $past(jumpPc)));

  p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> (op == 6'd43));

endmodule

bind sc_core sc_core_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .pc        (pc),
  .instrWord (instrWord),
  .memWrEn   (memWrEn)
);

// File: tb/sc_core_tb.sv
module sc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0;
  logic        loadToData = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [31:0] pc, memWrAddr, memWrData;
  logic        memWrEn;

  always #5 clk = ~clk;

  sc_core dut_i (
    .clk (clk), .rst (rst), .loadEn (loadEn), .loadToData (loadToData),
    .loadAddr (loadAddr), .loadData (loadData), .pc (pc),
    .memWrEn (memWrEn), .memWrAddr (memWrAddr), .memWrData (memWrData)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic done  = 1'b0;

  logic [31:0] prog  [64];
  logic [31:0] mDmem [64];
  logic [31:0] mReg  [32];
  logic [31:0] mPc;
  string       lastTag;

  function automatic logic [31:0] encR(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] encJ(input int tgtWord);
    return {6'd2, tgtWord[25:0]};
  endfunction

  function automatic logic [31:0] refAlu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'd34:   return a - b;
      6'd36:   return a & b;
      6'd37:   return a | b;
      6'd42:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // instruction-level reference step
  task automatic modelStep();
    logic [31:0] ins, sx, addr, p4;
    logic [5:0]  op;
    int rs, rt, rd;
    ins = prog[mPc[7:2]];
    op = ins[31:26];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx = {{16{ins[15]}}, ins[15:0]};
    addr = mReg[rs] + sx;
    p4 = mPc + 32'd4;
    lastTag = "R2";
    mPc = p4;
    case (op)
      6'd0:  if (rd != 0) mReg[rd] = refAlu(ins[5:0], mReg[rs], mReg[rt]);
      6'd35: if (rt != 0) mReg[rt] = mDmem[addr[7:2]];
      6'd43: mDmem[addr[7:2]] = mReg[rt];
      6'd4: begin
        lastTag = "R6";
        if (mReg[rs] == mReg[rt]) mPc = p4 + {sx[29:0], 2'b00};
      end
      6'd2: begin
        lastTag = "R7";
        mPc = {p4[31:28], ins[25:0], 2'b00};
      end
      default: ;
    endcase
  endtask

  task automatic preload(input logic toData, input int idx, input logic [31:0] val);
    loadEn = 1'b1; loadToData = toData; loadAddr = idx[5:0]; loadData = val;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mReg[i] = '0;
    for (int i = 0; i < 64; i++) begin prog[i] = '0; mDmem[i] = '0; end

    // data image: r1..r7 random (r2 differs from r1), word 7 = base 40
    for (int i = 0; i < 10; i++) mDmem[i] = $urandom;
    mDmem[1] = mDmem[0] ^ 32'h1;
    mDmem[7] = 32'd40;

    // program image
    for (int i = 0; i < 7; i++) prog[i] = encI(6'd35, 0, i + 1, 4 * i);
    prog[7] = encI(6'd35, 0, 8, 28);
    prog[8] = encI(6'd35, 8, 9, -4);               // R4 negative offset
    for (int k = 0; k < 18; k++) begin
      logic [5:0] fnList [5];
      int rd;
      fnList = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42};
      rd = 1 + int'($urandom % 15);
      prog[9 + 2*k]  = encR(fnList[$urandom % 5], 1 + int'($urandom % 15),
                            1 + int'($urandom % 15), rd);         // R3, R9
      prog[10 + 2*k] = encI(6'd43, 0, rd, 128 + 4 * (k % 8));     // R5
    end
    prog[45] = encR(6'd32, 1, 2, 0);      // R8 write to r0 dropped
    prog[46] = encI(6'd43, 0, 0, 132);
    prog[47] = encR(6'd32, 11, 1, 11);    // R9 rs == rd
    prog[48] = encI(6'd43, 0, 11, 136);
    prog[49] = encI(6'd4, 1, 1, 1);       // R6 taken, skips 50
    prog[50] = encI(6'd43, 0, 2, 140);
    prog[51] = encI(6'd4, 1, 2, 3);       // R6 not taken
    prog[52] = encI(6'd43, 0, 9, 144);
    prog[53] = encJ(60);                  // R7
    for (int i = 54; i < 60; i++) prog[i] = encI(6'd43, 0, 4, 148);
    prog[60] = encI(6'd43, 0, 5, 152);
    prog[61] = encR(6'd42, 1, 2, 12);
    prog[62] = encI(6'd43, 0, 12, 156);
    prog[63] = encJ(63);

    @(negedge clk);
    // R10: preload through the port while reset holds
    for (int i = 0; i < 64; i++) preload(1'b0, i, prog[i]);
    for (int i = 0; i < 10; i++) preload(1'b1, i, mDmem[i]);

    // R1 reset state
    check(pc == 32'd0, "R1", "pc in reset", pc, 32'd0);
    check(memWrEn == 1'b0, "R1", "store strobe in reset", {31'd0, memWrEn}, 32'd0);
    rst = 1'b0;
    mPc = '0;
    lastTag = "R1";

    for (int cyc = 0; cyc < 90; cyc++) begin
      logic [31:0] ins, sx;
      ins = prog[mPc[7:2]];
      sx = {{16{ins[15]}}, ins[15:0]};
      check(pc == mPc, lastTag, "program counter", pc, mPc);
      if (ins[31:26] == 6'd43) begin
        // R5 strobe; data reflects R3/R4/R8/R9 results
        check(memWrEn == 1'b1, "R5", "store strobe", {31'd0, memWrEn}, 32'd1);
        check(memWrAddr == mReg[ins[25:21]] + sx, "R5", "store address",
              memWrAddr, mReg[ins[25:21]] + sx);
        check(memWrData == mReg[ins[20:16]], "R5", "store data",
              memWrData, mReg[ins[20:16]]);
      end else begin
        check(memWrEn == 1'b0, "R5", "no strobe", {31'd0, memWrEn}, 32'd0);
      end
      modelStep();
      @(negedge clk);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule